// File: doc/BRIEF.md
# Double-Buffered Control Registers with Calibration Start

This block holds a small set of control registers in two copies. A host writes through a plain address/data port, and each write lands only in the staging copy. A single-cycle update strobe moves the whole staging copy into the live copy in one clock. Only the live copy drives the hardware, so the host can stage several fields and apply them together.

Register 0 is the control register. Its bit 0 requests a calibration, and the block emits a one-cycle start pulse when that live bit rises from 0 to 1. To launch a calibration, the host writes 0 and strobes, then writes 1 and strobes again. Bits [2:1] select the calibration clock divide ratio. Bits [4:3] select how an external sync input resets the reference and feedback counters: not at all, directly and asynchronously, or through a two-flop synchronizer. All other registers are plain bytes that are passed out from the live copy.

Top module: `cal_shadow_regs`

## Requirements
- R1: After reset, both copies hold defaults. Register 0 is 0x06, meaning the calibrate bit is 0, the divider select is 11 and the sync mode is 00. Every other register is 0x00. cal_start and ctr_rst are 0, and cal_div is 16.
- R2: A write with wr_en high and wr_addr below NREG changes only the staging copy. act_regs does not change until a later update strobe.
- R3: An update strobe copies every staging register into the live copy at that clock edge. If a write falls in the same cycle as the strobe, that write is not part of the copy. act_regs holds register i in bits [i*DW +: DW].
- R4: A write with wr_addr at or above NREG is ignored. A later update strobe shows every register unchanged.
- R5: cal_start is high for exactly one cycle, in the cycle after the strobe edge that changes live register 0 bit 0 from 0 to 1. It stays low for a strobe that leaves the bit at 1 or clears it.
- R6: cal_div reports the divide ratio given by live register 0 bits [2:1]: 00 gives 2, 01 gives 4, 10 gives 8, 11 gives 16.
- R7: When live register 0 bits [4:3] are 01, ctr_rst follows sync_in combinationally.
- R8: When bits [4:3] are 10, ctr_rst equals sync_in as it was sampled two clock edges earlier.
- R9: When bits [4:3] are 00 or 11, ctr_rst stays 0 whatever sync_in does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write enable for the staging copy |
| wr_addr | input | AW | Register address |
| wr_data | input | DW | Write data |
| upd | input | 1 | Update strobe: staging copy to live copy |
| sync_in | input | 1 | External counter sync input |
| act_regs | output | NREG*DW | Live copy, register i in bits [i*DW +: DW] |
| cal_start | output | 1 | One-cycle calibration start pulse |
| cal_div | output | 5 | Calibration clock divide ratio (2, 4, 8 or 16) |
| ctr_rst | output | 1 | Reset to the reference and feedback counters |

## Verification
The bench repeats strobes while the calibrate bit is already 1 and checks that no pulse appears. A design that edge-detected the staging bit, or that compared levels instead of edges, would pulse there or pulse too early. It puts a write and a strobe in the same cycle. A design that forwarded the new data would show it in the live copy one strobe too soon. It writes to addresses past the last register, which would alias onto a real register if the address were truncated. It toggles sync_in in every mode, which catches a synchronizer that is one stage short or long and catches a reset that leaks through in the no-action codes.

// File: rtl/cal_shadow_regs.sv
module cal_shadow_regs #(
  parameter int NREG = 6,
  parameter int DW   = 8,
  parameter int AW   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               upd,
  input  logic               sync_in,
  output logic [NREG*DW-1:0] act_regs,
  output logic               cal_start,
  output logic [4:0]         cal_div,
  output logic               ctr_rst
);
  localparam logic [DW-1:0] CTRL_RST = DW'(8'h06);
  localparam logic [NREG-1:0][DW-1:0] RSTV = {{((NREG-1)*DW){1'b0}}, CTRL_RST};

  logic [NREG-1:0][DW-1:0] buf_q, act_q;
  logic cal_q, s1, s2;
  logic hit;

  assign hit = wr_en && (int'(wr_addr) < NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= RSTV;
      act_q <= RSTV;
      cal_q <= 1'b0;
      s1    <= 1'b0;
      s2    <= 1'b0;
    end else begin
      if (upd) act_q <= buf_q;
      if (hit) buf_q[wr_addr] <= wr_data;
      cal_q <= act_q[0][0];
      s1    <= sync_in;
      s2    <= s1;
    end
  end

  assign act_regs  = act_q;
  assign cal_start = act_q[0][0] & ~cal_q;
  assign cal_div   = 5'b00010 << act_q[0][2:1];

  always_comb begin
    case (act_q[0][4:3])
      2'b01:   ctr_rst = sync_in;
      2'b10:   ctr_rst = s2;
      default: ctr_rst = 1'b0;
    endcase
  end
endmodule

// File: rtl/cal_shadow_regs_sva.sv
module cal_shadow_regs_sva #(
  parameter int NREG = 6,
  parameter int DW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               upd,
  input logic               sync_in,
  input logic [NREG*DW-1:0] act_regs,
  input logic               cal_start,
  input logic [4:0]         cal_div,
  input logic               ctr_rst
);
  logic [1:0] mode;
  assign mode = act_regs[4:3];

  assert_hold_no_upd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(act_regs));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start);

  assert_pulse_on_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !act_regs[0]) |=> (cal_start == act_regs[0]));

  assert_div_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cal_div) == 1) && !cal_div[0]);

  assert_async_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |-> (ctr_rst == sync_in));

  assert_quiet_modes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |-> !ctr_rst);
endmodule

bind cal_shadow_regs cal_shadow_regs_sva #(.NREG(NREG), .DW(DW)) u_sva (
  .clk(clk), .rst_n(rst_n), .upd(upd), .sync_in(sync_in),
  .act_regs(act_regs), .cal_start(cal_start), .cal_div(cal_div), .ctr_rst(ctr_rst)
);

// File: tb/sim_cal_shadow_regs.sv
`timescale 1ns/1ps
module sim_cal_shadow_regs;
  localparam int NREG = 6, DW = 8, AW = 3;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, upd = 0, sync_in = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NREG*DW-1:0] act_regs;
  logic cal_start, ctr_rst;
  logic [4:0] cal_div;

  cal_shadow_regs #(.NREG(NREG), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .upd(upd), .sync_in(sync_in), .act_regs(act_regs), .cal_start(cal_start),
    .cal_div(cal_div), .ctr_rst(ctr_rst)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  logic [DW-1:0] mbuf [NREG];
  logic [DW-1:0] mact [NREG];
  logic ms1 = 0, ms2 = 0, exp_cs = 0;

  function automatic logic [4:0] exp_div(input logic [1:0] sel);
    return 5'd2 << sel;
  endfunction

  function automatic logic exp_rst(input logic [1:0] mode, input logic s, input logic d2);
    case (mode)
      2'b01:   return s;
      2'b10:   return d2;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [NREG*DW-1:0] flat();
    logic [NREG*DW-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*DW +: DW] = mact[i];
    return f;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R3 live copy", 64'(act_regs), 64'(flat()));
    chk("R5 cal_start", 64'(cal_start), 64'(exp_cs));
    chk("R6 cal_div", 64'(cal_div), 64'(exp_div(mact[0][2:1])));
    case (mact[0][4:3])
      2'b01:   chk("R7 ctr_rst", 64'(ctr_rst), 64'(exp_rst(2'b01, sync_in, ms2)));
      2'b10:   chk("R8 ctr_rst", 64'(ctr_rst), 64'(exp_rst(2'b10, sync_in, ms2)));
      default: chk("R9 ctr_rst", 64'(ctr_rst), 64'(exp_rst(mact[0][4:3], sync_in, ms2)));
    endcase
  endtask

  task automatic step();
    logic old0;
    @(posedge clk);
    old0 = mact[0][0];
    if (upd) for (int i = 0; i < NREG; i++) mact[i] = mbuf[i];
    if (wr_en && int'(wr_addr) < NREG) mbuf[wr_addr] = wr_data;
    exp_cs = mact[0][0] & ~old0;
    ms2 = ms1;
    ms1 = sync_in;
    @(negedge clk);
    check_all();
  endtask

  task automatic drive(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic u, input logic s);
    wr_en = we; wr_addr = a; wr_data = d; upd = u; sync_in = s;
    step();
    wr_en = 0; upd = 0;
  endtask

  initial begin
    #500000;
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NREG*DW-1:0] snap;
    void'($urandom(32'd1234));
    for (int i = 0; i < NREG; i++) begin
      mbuf[i] = (i == 0) ? 8'h06 : 8'h00;
      mact[i] = mbuf[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 regs", 64'(act_regs), 64'(48'h06));
    chk("R1 cal_start", 64'(cal_start), 64'd0);
    chk("R1 ctr_rst", 64'(ctr_rst), 64'd0);
    chk("R1 cal_div", 64'(cal_div), 64'd16);
    rst_n = 1;

    // R2: write without strobe leaves live copy alone
    snap = act_regs;
    drive(1, 3'd2, 8'hA5, 0, 0);
    drive(1, 3'd0, 8'h01, 0, 0);
    chk("R2 no strobe", 64'(act_regs), 64'(snap));
    chk("R5 no pulse before strobe", 64'(cal_start), 64'd0);

    // R5: write 1 then strobe -> pulse in the next cycle only
    drive(0, 0, 0, 1, 0);
    chk("R5 pulse", 64'(cal_start), 64'd1);
    drive(0, 0, 0, 0, 0);
    chk("R5 pulse ends", 64'(cal_start), 64'd0);
    drive(0, 0, 0, 1, 0);
    chk("R5 no pulse when bit stays 1", 64'(cal_start), 64'd0);
    drive(1, 3'd0, 8'h00, 0, 0);
    drive(0, 0, 0, 1, 0);
    chk("R5 no pulse on clear", 64'(cal_start), 64'd0);
    drive(1, 3'd0, 8'h01, 0, 0);
    drive(0, 0, 0, 1, 0);
    chk("R5 second pulse", 64'(cal_start), 64'd1);

    // R3: write in same cycle as strobe is not copied
    drive(1, 3'd5, 8'h3C, 1, 0);
    chk("R3 same-cycle write excluded", 64'(act_regs[5*DW +: DW]), 64'd0);
    drive(0, 0, 0, 1, 0);
    chk("R3 copied on next strobe", 64'(act_regs[5*DW +: DW]), 64'h3C);

    // R4: out-of-range writes ignored
    snap = act_regs;
    drive(1, 3'd6, 8'hFF, 0, 0);
    drive(1, 3'd7, 8'hEE, 0, 0);
    drive(0, 0, 0, 1, 0);
    chk("R4 out of range", 64'(act_regs), 64'(snap));

    // R6: all divider codes
    for (int k = 0; k < 4; k++) begin
      drive(1, 3'd0, 8'(k << 1), 0, 0);
      drive(0, 0, 0, 1, 0);
      chk("R6 divider", 64'(cal_div), 64'(5'd2 << k));
    end

    // R7: async mode
    drive(1, 3'd0, 8'h08, 0, 0);
    drive(0, 0, 0, 1, 0);
    sync_in = 1; #1;
    chk("R7 async follow", 64'(ctr_rst), 64'd1);
    // R8: sync mode, two-edge delay
    drive(1, 3'd0, 8'h10, 0, 0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 1);
    chk("R8 not yet", 64'(ctr_rst), 64'd0);
    drive(0, 0, 0, 0, 0);
    chk("R8 after two edges", 64'(ctr_rst), 64'd1);
    drive(0, 0, 0, 0, 0);
    chk("R8 release", 64'(ctr_rst), 64'd0);
    // R9: mode 11 ignores sync
    drive(1, 3'd0, 8'h18, 0, 1);
    drive(0, 0, 0, 1, 1);
    drive(0, 0, 0, 0, 1);
    chk("R9 mode 11 quiet", 64'(ctr_rst), 64'd0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'($urandom_range(0, 7));
      d = DW'($urandom);
      if (a == 0 && $urandom_range(0, 1) == 1) d[0] = ~mbuf[0][0];
      drive($urandom_range(0, 2) != 0, a, d, $urandom_range(0, 3) == 0,
            $urandom_range(0, 1) == 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule